// File: doc/BRIEF.md
# Fetch Program Counter with Upper-Byte Carry Stall

This block holds the 16-bit fetch address of an 8-bit core whose program and data memories are separate. The fetch address goes to program memory together with a valid strobe. In each cycle the block does one of three things:

- It steps forward by the length of the current instruction.
- It loads a branch target.
- It stays where it is.

The instruction decoder and the memory contents sit outside the block. The requester supplies the instruction length and the branch target.

A sequential step can carry into the upper address byte. When it does, the block spends one extra cycle in a stall state before it presents the new address. While it stalls, the valid strobe is low and `busy` is high. A branch load never stalls, whatever address it targets. Crossing a 128-byte flash block boundary inside the same upper byte costs nothing, so block boundaries do not show in program timing.

The control is a two-state machine:

- **RUN**: the address is valid. The transitions out of RUN are:
  - *hold*: no request, or a length of zero.
  - *step*: the upper byte is unchanged, so the address is updated at once.
  - *branch*: the target is loaded.
  - *carry*: the upper byte changes, so the new address is parked and the machine moves to CARRY_STALL.
- **CARRY_STALL**: lasts exactly one cycle. Its only transition is *commit*: the parked address becomes the fetch address and the machine returns to RUN.

Top module: `fetch_pc`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `fetch_addr` is 0000h, `fetch_vld` is 1 and `busy` is 0.
- R2: In RUN, a step with `step_len` of 1, 2 or 3 (binary 01, 10, 11) whose sum leaves bits 15:8 unchanged shows `fetch_addr` plus the length after the next clock edge, with `fetch_vld` high throughout.
- R3: A step request with `step_len` 00, or no request at all, leaves `fetch_addr` unchanged.
- R4: A step whose sum changes bits 15:8 produces one cycle with `busy` high, `fetch_vld` low and the old `fetch_addr`. In the following cycle the new address appears with `fetch_vld` high and `busy` low.
- R5: A branch request loads `br_target` into `fetch_addr` after one clock edge with no stall, even when the upper byte changes.
- R6: When a step request and a branch request arrive in the same cycle, the branch wins.
- R7: Step and branch requests presented while `busy` is high are ignored. Only the parked address is committed.
- R8: The address arithmetic wraps modulo 2^16. A step from FFFEh by 2 stalls and then shows 0000h.
- R9: A step that crosses a 128-byte boundary without changing bits 15:8 (for example 007Fh to 0080h) does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_req | input | 1 | Request a sequential step |
| step_len | input | 2 | Instruction length in bytes (1 to 3; 0 means no move) |
| br_req | input | 1 | Request a branch load |
| br_target | input | 16 | Branch target address |
| fetch_addr | output | 16 | Current program fetch address |
| fetch_vld | output | 1 | Fetch address is valid this cycle |
| busy | output | 1 | Carry stall in progress; requests are ignored |

## Verification
The hardest situation to bring about is a request that arrives during the single stall cycle, because the window exists for only one clock. The stimulus first branches to 00FEh and then steps by 3, which guarantees a carry. In the very next cycle it drives a branch and a step at the same time, and the scoreboard expects both to be discarded in favour of 0101h. The same method reaches the wrap at FFFEh and a carry after a branch that itself changed the upper byte.

// File: rtl/fetch_pc_pkg.sv
`timescale 1ns/1ps
package fetch_pc_pkg;
    parameter int ADDR_W    = 16;
    parameter int LEN_W     = 2;
    parameter int PAGE_LSB  = 8;

    typedef enum logic [0:0] {
        ST_RUN         = 1'b0,
        ST_CARRY_STALL = 1'b1
    } pc_state_e;
endpackage

// File: rtl/fetch_pc_adder.sv
`timescale 1ns/1ps
module fetch_pc_adder #(
    parameter int ADDR_W   = 16,
    parameter int LEN_W    = 2,
    parameter int PAGE_LSB = 8
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [LEN_W-1:0]  len,
    output logic [ADDR_W-1:0] seq_addr,
    output logic              hi_carry
);
    localparam int PAD_W = ADDR_W - LEN_W;

    always_comb begin
        seq_addr = cur_addr + {{PAD_W{1'b0}}, len};
        hi_carry = (seq_addr[ADDR_W-1:PAGE_LSB] != cur_addr[ADDR_W-1:PAGE_LSB]);
    end
endmodule

// File: rtl/fetch_pc_ctrl.sv
`timescale 1ns/1ps
module fetch_pc_ctrl
    import fetch_pc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_req,
    input  logic [LEN_W-1:0]  step_len,
    input  logic              br_req,
    input  logic [ADDR_W-1:0] br_target,
    input  logic [ADDR_W-1:0] seq_addr,
    input  logic              hi_carry,
    output logic [ADDR_W-1:0] pc_q,
    output logic              fetch_vld,
    output logic              busy
);
    pc_state_e         state_q, state_d;
    logic [ADDR_W-1:0] pc_d, park_q, park_d;
    logic              step_ok;

    assign step_ok = step_req && (step_len != '0);

    // next-state and datapath selection
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        park_d  = park_q;
        unique case (state_q)
            ST_RUN: begin
                if (br_req) begin
                    pc_d = br_target;                 // branch
                end else if (step_ok && hi_carry) begin
                    park_d  = seq_addr;               // carry
                    state_d = ST_CARRY_STALL;
                end else if (step_ok) begin
                    pc_d = seq_addr;                  // step
                end
            end
            ST_CARRY_STALL: begin
                pc_d    = park_q;                     // commit
                state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            pc_q    <= '0;
            park_q  <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            park_q  <= park_d;
        end
    end

    // outputs
    always_comb begin
        fetch_vld = 1'b0;
        busy      = 1'b0;
        unique case (state_q)
            ST_RUN:         fetch_vld = 1'b1;
            ST_CARRY_STALL: busy      = 1'b1;
            default: ;
        endcase
    end

    assert_stall_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy && fetch_vld));
    assert_stall_holds_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(pc_q));
    assert_carry_enters_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !br_req && step_ok && hi_carry) |=> busy);
    assert_step_same_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !br_req && step_ok && !hi_carry)
        |=> (pc_q == $past(seq_addr) && !busy));
    assert_branch_no_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && br_req) |=> (pc_q == $past(br_target) && !busy));
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !br_req && !step_ok) |=> $stable(pc_q));
    assert_vld_excl_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({fetch_vld, busy}));
endmodule

// File: rtl/fetch_pc.sv
`timescale 1ns/1ps
module fetch_pc
    import fetch_pc_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int LEN_W    = 2,
    parameter int PAGE_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_req,
    input  logic [LEN_W-1:0]  step_len,
    input  logic              br_req,
    input  logic [ADDR_W-1:0] br_target,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_vld,
    output logic              busy
);
    logic [ADDR_W-1:0] seq_addr;
    logic              hi_carry;

    fetch_pc_adder #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_LSB(PAGE_LSB)) u_adder (
        .cur_addr (fetch_addr),
        .len      (step_len),
        .seq_addr (seq_addr),
        .hi_carry (hi_carry)
    );

    fetch_pc_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_req  (step_req),
        .step_len  (step_len),
        .br_req    (br_req),
        .br_target (br_target),
        .seq_addr  (seq_addr),
        .hi_carry  (hi_carry),
        .pc_q      (fetch_addr),
        .fetch_vld (fetch_vld),
        .busy      (busy)
    );
endmodule

// File: tb/fetch_pc_tb.sv
`timescale 1ns/1ps
module fetch_pc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_req = 1'b0;
    logic [1:0]  step_len = 2'd0;
    logic        br_req = 1'b0;
    logic [15:0] br_target = 16'h0;
    logic [15:0] fetch_addr;
    logic        fetch_vld, busy;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic [17:0] exp_q[$];   // {addr, vld, busy}
    string       tag_q[$];

    logic [15:0] m_pc = 16'h0, m_park = 16'h0;
    bit          m_busy = 1'b0;

    always #2 clk = ~clk;

    fetch_pc u_dut (
        .clk(clk), .rst_n(rst_n), .step_req(step_req), .step_len(step_len),
        .br_req(br_req), .br_target(br_target),
        .fetch_addr(fetch_addr), .fetch_vld(fetch_vld), .busy(busy)
    );

    task automatic compare(input logic [17:0] expv, input string tag);
        vectors++;
        if ({fetch_addr, fetch_vld, busy} !== expv) begin
            miscompares++;
            $display("FAIL %s: got addr=%h vld=%b busy=%b, expected addr=%h vld=%b busy=%b",
                     tag, fetch_addr, fetch_vld, busy, expv[17:2], expv[1], expv[0]);
        end
    endtask

    // driver: applies one cycle of stimulus and predicts the post-edge outputs
    task automatic drive(input bit sr, input logic [1:0] sl, input bit br,
                         input logic [15:0] bt, input string tag);
        logic [15:0] s;
        @(negedge clk);
        step_req = sr; step_len = sl; br_req = br; br_target = bt;
        if (m_busy) begin
            m_pc = m_park; m_busy = 1'b0;
        end else if (br) begin
            m_pc = bt;
        end else if (sr && sl != 2'd0) begin
            s = m_pc + {14'd0, sl};
            if (s[15:8] != m_pc[15:8]) begin
                m_park = s; m_busy = 1'b1;
            end else begin
                m_pc = s;
            end
        end
        exp_q.push_back({m_pc, ~m_busy, m_busy});
        tag_q.push_back(tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare({16'h0000, 1'b1, 1'b0}, "R1 in reset");
        rst_n = 1'b1;
        @(posedge clk); #1;
        compare({16'h0000, 1'b1, 1'b0}, "R1 after reset");

        drive(1, 2'd1, 0, 16'h0,    "R2 len1");
        drive(1, 2'd3, 0, 16'h0,    "R2 len3");
        drive(1, 2'd2, 0, 16'h0,    "R2 len2");
        drive(1, 2'd0, 0, 16'h0,    "R3 len0");
        drive(0, 2'd3, 0, 16'h0,    "R3 idle");
        drive(0, 2'd0, 1, 16'h007E, "R5 branch same page");
        drive(1, 2'd1, 0, 16'h0,    "R2 to 007F");
        drive(1, 2'd1, 0, 16'h0,    "R9 block cross 0080");
        drive(0, 2'd0, 1, 16'h00FE, "R5 branch 00FE");
        drive(1, 2'd3, 0, 16'h0,    "R4 stall cycle");
        drive(1, 2'd2, 1, 16'h1234, "R7 ignored during stall");
        drive(1, 2'd1, 1, 16'h5555, "R6 branch beats step");
        drive(0, 2'd0, 1, 16'h12FF, "R5 branch upper change no stall");
        drive(1, 2'd1, 0, 16'h0,    "R4 stall at 12FF");
        drive(0, 2'd0, 0, 16'h0,    "R4 commit 1300");
        drive(0, 2'd0, 1, 16'hFFFE, "R5 branch FFFE");
        drive(1, 2'd2, 0, 16'h0,    "R8 wrap stall");
        drive(1, 2'd1, 0, 16'h0,    "R8 wrap commit 0000");
        drive(1, 2'd2, 0, 16'h0,    "R2 after wrap");
        drive(0, 2'd0, 0, 16'h0,    "R3 final idle");
        @(posedge clk); #2;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got no completion, expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule